// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides which of eleven interrupt sources a small processor core should service next, and when. Each source has its own enable bit and a priority bit that puts it on one of two levels. A global enable masks everything. Within a level, a fixed ranking breaks ties. The sources are two external pins, two timer overflows, the local serial port, two DMA completions and four status flags from a serial link controller. Each clock cycle is treated as one machine cycle. The request flags are captured at one edge and resolved during the following cycle.

A call pulse carries an 8-bit vector address. It is issued only in the last cycle of an instruction that is not itself a return or a write to the enable or priority registers. It is also held back while a service routine of the same or a higher level is still running. A two-bit in-service record tracks which levels are active, and a return strobe releases the higher active level. The external pins can each be set to falling-edge or low-level sensing. Edge flags and timer flags are cleared automatically when they are vectored; the other flags are not.

Top module: `irq_arbiter`

## Requirements
- R1: Within one level the winner is the lowest entry of this ranking (source: vector): ext0 03h, link rx-ok 2Bh, timer0 0Bh, link rx-err 33h, DMA0 3Bh, ext1 13h, link tx-ok 43h, DMA1 53h, timer1 1Bh, link tx-err 4Bh, local serial 23h. `vec_addr` carries that vector while `call_req` is 1 and reads 00h otherwise.
- R2: A high-level request can interrupt a low-level routine. A low-level request never interrupts a high-level routine. A request never interrupts a routine of its own level.
- R3: A flag that is set at clock edge k is captured at edge k+1, so it can produce `call_req` no earlier than the cycle that follows edge k+1.
- R4: `call_req` is asserted only in a cycle where `instr_last` is 1 and `instr_blocks` is 0.
- R5: A request that goes away before it is honoured leaves no trace. Each resolution uses only the flags captured at the most recent edge.
- R6: With `ext_edge[n]`=1, a falling edge on `ext_pin_n[n]` between two edges sets `ext_flag[n]`, and vectoring that source clears it. With `ext_edge[n]`=0, `ext_flag[n]` is the inverse of the pin at the last edge and is never cleared by vectoring.
- R7: A `tmr_ovf[n]` pulse sets `tmr_flag[n]`, and vectoring that timer clears it. The local serial request is `ser_ri | ser_ti` and is never cleared by this block.
- R8: `en_main[7]`=0 masks every source. The source enables are: `en_main` bits 4..0 for serial, timer1, ext1, timer0 and ext0; `en_ext` bits 0..5 for link rx-ok, link rx-err, DMA0, link tx-ok, DMA1 and link tx-err.
- R9: A priority bit of 1 selects the high level. `pri_main` bits 4..0 and `pri_ext` bits 5..0 use the same positions as the enables. A high-level request wins over any low-level request, whatever their ranking.
- R10: A call at level L sets `in_service[L]`. A `reti` strobe clears the highest set bit of `in_service`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | 1 = falling-edge sensing, 0 = low-level sensing |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_ri | input | 1 | Local serial receive flag |
| ser_ti | input | 1 | Local serial transmit flag |
| dma_done | input | 2 | DMA channel completion flags |
| link_stat | input | 4 | Link flags: bit0 rx-ok, bit1 rx-err, bit2 tx-ok, bit3 tx-err |
| en_main | input | 8 | Global enable (bit 7) and main source enables |
| en_ext | input | 6 | Enables for the DMA and link sources |
| pri_main | input | 5 | Priority bits for the main sources |
| pri_ext | input | 6 | Priority bits for the DMA and link sources |
| instr_last | input | 1 | Current cycle is the last cycle of an instruction |
| instr_blocks | input | 1 | Current instruction is a return or an enable/priority write |
| reti | input | 1 | Return-from-interrupt strobe |
| call_req | output | 1 | Call request pulse |
| vec_addr | output | 8 | Vector address during `call_req` |
| in_service | output | 2 | Active service levels, bit 1 = high |
| ext_flag | output | 2 | External interrupt flags |
| tmr_flag | output | 2 | Timer overflow flags |

## Verification
The ranking is tested by raising all eleven sources together and then retiring each winner in turn. This separates a correct ranking from a plain index order or a wrong vector table. Nesting is tested with pairs in which the better-ranked source sits on the low level. That shows whether priority overrides ranking, and whether same-level or low-level requests are correctly refused while a routine is active. Other tests hold a request while the instruction boundary is absent or blocked, withdraw a request before it is served, and compare edge and level pins that stay low after vectoring. These tell apart flags that clear on vectoring from flags that persist, and show that the arbiter latches nothing.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_pin_n,
  input  logic [1:0] ext_edge,
  input  logic [1:0] tmr_ovf,
  input  logic       ser_ri,
  input  logic       ser_ti,
  input  logic [1:0] dma_done,
  input  logic [3:0] link_stat,
  input  logic [7:0] en_main,
  input  logic [5:0] en_ext,
  input  logic [4:0] pri_main,
  input  logic [5:0] pri_ext,
  input  logic       instr_last,
  input  logic       instr_blocks,
  input  logic       reti,
  output logic       call_req,
  output logic [7:0] vec_addr,
  output logic [1:0] in_service,
  output logic [1:0] ext_flag,
  output logic [1:0] tmr_flag
);
  localparam int IW = $clog2(NSRC);

  logic [1:0]      pin_q;
  logic [NSRC-1:0] raw, snap, en_v, pri_v, act, clr_v;
  logic [IW-1:0]   win_idx;
  logic            win_ok, win_hi;

  function automatic logic [7:0] vec_of(input logic [IW-1:0] i);
    case (i)
      0: vec_of = 8'h03;  1: vec_of = 8'h2B;  2: vec_of = 8'h0B;
      3: vec_of = 8'h33;  4: vec_of = 8'h3B;  5: vec_of = 8'h13;
      6: vec_of = 8'h43;  7: vec_of = 8'h53;  8: vec_of = 8'h1B;
      9: vec_of = 8'h4B;  10: vec_of = 8'h23;
      default: vec_of = 8'h00;
    endcase
  endfunction

  assign raw   = {ser_ri | ser_ti, link_stat[3], tmr_flag[1], dma_done[1], link_stat[2],
                  ext_flag[1], dma_done[0], link_stat[1], tmr_flag[0], link_stat[0], ext_flag[0]};
  assign en_v  = {en_main[4], en_ext[5], en_main[3], en_ext[4], en_ext[3], en_main[2],
                  en_ext[2], en_ext[1], en_main[1], en_ext[0], en_main[0]} & {NSRC{en_main[7]}};
  assign pri_v = {pri_main[4], pri_ext[5], pri_main[3], pri_ext[4], pri_ext[3], pri_main[2],
                  pri_ext[2], pri_ext[1], pri_main[1], pri_ext[0], pri_main[0]};
  assign act   = snap & en_v;

  always_comb begin
    win_idx = '0;
    win_hi  = 1'b0;
    win_ok  = 1'b0;
    if (|(act & pri_v) && !in_service[1]) begin
      win_ok = 1'b1;
      win_hi = 1'b1;
      for (int i = NSRC - 1; i >= 0; i--)
        if (act[i] && pri_v[i]) win_idx = IW'(i);
    end else if (|(act & ~pri_v) && in_service == 2'b00) begin
      win_ok = 1'b1;
      for (int i = NSRC - 1; i >= 0; i--)
        if (act[i] && !pri_v[i]) win_idx = IW'(i);
    end
  end

  assign call_req = win_ok && instr_last && !instr_blocks;
  assign vec_addr = call_req ? vec_of(win_idx) : 8'h00;
  assign clr_v    = call_req ? (NSRC'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 2'b11;
      ext_flag <= 2'b00;
      tmr_flag <= 2'b00;
      snap     <= '0;
    end else begin
      pin_q       <= ext_pin_n;
      ext_flag[0] <= ext_edge[0] ? ((ext_flag[0] & ~clr_v[0]) | (pin_q[0] & ~ext_pin_n[0]))
                                 : ~ext_pin_n[0];
      ext_flag[1] <= ext_edge[1] ? ((ext_flag[1] & ~clr_v[5]) | (pin_q[1] & ~ext_pin_n[1]))
                                 : ~ext_pin_n[1];
      tmr_flag[0] <= (tmr_flag[0] & ~clr_v[2]) | tmr_ovf[0];
      tmr_flag[1] <= (tmr_flag[1] & ~clr_v[8]) | tmr_ovf[1];
      snap        <= raw & ~clr_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_service <= 2'b00;
    else begin
      if (call_req)                  in_service[win_hi] <= 1'b1;
      if (reti && in_service[1])     in_service[1] <= 1'b0;
      else if (reti && in_service[0]) in_service[0] <= 1'b0;
    end
  end

  AST_CALL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> instr_last && !instr_blocks); // R4
  AST_NO_CALL_OVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[1] |-> !call_req); // R2
  AST_LOW_NESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    call_req && in_service == 2'b01 && !reti |=> in_service == 2'b11); // R2
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !en_main[7] |-> !call_req); // R8
  AST_RETURN_POPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !call_req && in_service == 2'b11 |=> in_service == 2'b01); // R10
  AST_TIMER0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    call_req && vec_addr == 8'h0B && !tmr_ovf[0] |=> !tmr_flag[0]); // R7
  AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !call_req |-> vec_addr == 8'h00); // R1
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00, dma_done = 2'b00;
  logic       ser_ri = 1'b0, ser_ti = 1'b0;
  logic [3:0] link_stat = 4'h0;
  logic [7:0] en_main = 8'h00;
  logic [5:0] en_ext = 6'h00, pri_ext = 6'h00;
  logic [4:0] pri_main = 5'h00;
  logic       instr_last = 1'b0, instr_blocks = 1'b0, reti = 1'b0;
  logic       call_req;
  logic [7:0] vec_addr;
  logic [1:0] in_service, ext_flag, tmr_flag;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_arbiter dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    instr_last = 0; instr_blocks = 0;
    ext_pin_n = 2'b11; ext_edge = 2'b00; tmr_ovf = 0; dma_done = 0;
    ser_ri = 0; ser_ti = 0; link_stat = 0;
    en_main = 0; en_ext = 0; pri_main = 0; pri_ext = 0;
    reti = 1; tick(); tick(); reti = 0; tick(); tick();
  endtask

  task automatic t_reset();
    #1;
    chk(call_req, 0, "reset call_req");
    chk(in_service, 0, "reset in_service");
    chk({ext_flag, tmr_flag}, 0, "reset flags");
  endtask

  task automatic t_timer_latency();
    en_main = 8'h82;
    tmr_ovf[0] = 1; tick(); tmr_ovf[0] = 0;
    chk(tmr_flag[0], 1, "R7 timer flag set");
    instr_last = 1; #1;
    chk(call_req, 0, "R3 not before capture");
    tick();
    chk({call_req, vec_addr}, {1'b1, 8'h0B}, "R3 call after capture");
    tick(); instr_last = 0;
    chk(tmr_flag[0], 0, "R7 timer cleared on vector");
    chk(in_service, 2'b01, "R10 low level set");
    reti = 1; tick(); reti = 0;
    chk(in_service, 2'b00, "R10 reti clears");
    idle();
  endtask

  task automatic t_ranking();
    logic [7:0] exp_v [11] = '{8'h03, 8'h2B, 8'h0B, 8'h33, 8'h3B, 8'h13,
                               8'h43, 8'h53, 8'h1B, 8'h4B, 8'h23};
    en_main = 8'h9F; en_ext = 6'h3F;
    ext_pin_n = 2'b00; tmr_ovf = 2'b11; dma_done = 2'b11; link_stat = 4'hF; ser_ri = 1;
    tick(); tmr_ovf = 0; tick(); tick();
    for (int i = 0; i < 11; i++) begin
      instr_last = 1; #1;
      chk({call_req, vec_addr}, {1'b1, exp_v[i]}, $sformatf("R1 rank %0d", i));
      tick(); instr_last = 0;
      case (i)
        0: ext_pin_n[0] = 1;  1: link_stat[0] = 0;  3: link_stat[1] = 0;
        4: dma_done[0] = 0;   5: ext_pin_n[1] = 1;  6: link_stat[2] = 0;
        7: dma_done[1] = 0;   9: link_stat[3] = 0;  10: ser_ri = 0;
        default: ;
      endcase
      reti = 1; tick(); reti = 0; tick(); tick();
    end
    idle();
  endtask

  task automatic t_nesting();
    en_main = 8'h90; en_ext = 6'h04; pri_ext = 6'h04;
    ser_ri = 1; tick(); instr_last = 1; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h23}, "R7 local serial call");
    tick();
    chk(call_req, 0, "R2 same level refused");
    dma_done[0] = 1; tick(); #1;
    chk({call_req, vec_addr}, {1'b1, 8'h3B}, "R2 high preempts low");
    tick(); dma_done[0] = 0;
    chk(in_service, 2'b11, "R10 both levels");
    instr_last = 0; reti = 1; tick(); reti = 0;
    chk(in_service, 2'b01, "R10 reti pops high first");
    idle();
    en_main = 8'h91; pri_main = 5'h10; ext_pin_n[0] = 0; ser_ti = 1;
    tick(); tick(); instr_last = 1; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h23}, "R9 priority beats rank");
    tick();
    chk({call_req, in_service}, {1'b0, 2'b10}, "R2 low waits under high");
    ser_ti = 0; instr_last = 0; reti = 1; tick(); reti = 0; tick(); instr_last = 1; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h03}, "R6 level ext0 after return");
    tick(); instr_last = 0;
    chk(ext_flag[0], 1, "R6 level flag not cleared");
    idle();
  endtask

  task automatic t_boundary();
    en_main = 8'h82; tmr_ovf[1] = 1; en_main[3] = 1;
    tick(); tmr_ovf[1] = 0; tick();
    instr_last = 1; instr_blocks = 1; #1;
    chk(call_req, 0, "R4 blocked instruction");
    instr_last = 0; instr_blocks = 0; #1;
    chk(call_req, 0, "R4 not last cycle");
    instr_last = 1; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h1B}, "R4 boundary allows");
    idle();
  endtask

  task automatic t_not_latched();
    en_main = 8'h80; en_ext = 6'h01; link_stat[0] = 1; tick(); tick();
    link_stat[0] = 0; tick(); tick(); instr_last = 1; #1;
    chk(call_req, 0, "R5 withdrawn request gone");
    idle();
  endtask

  task automatic t_edge_and_mask();
    ext_edge = 2'b01; en_main = 8'h01;
    tick(); ext_pin_n[0] = 0; tick();
    chk(ext_flag[0], 1, "R6 falling edge sets");
    tick(); instr_last = 1; #1;
    chk(call_req, 0, "R8 global off masks");
    en_main = 8'h81; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h03}, "R8 global on calls");
    tick(); instr_last = 0;
    chk(ext_flag[0], 0, "R6 edge flag cleared though pin low");
    idle();
    en_main = 8'h80; en_ext = 6'h3D; dma_done = 2'b11; link_stat = 4'h2; ser_ri = 1;
    tick(); tick(); instr_last = 1; #1;
    chk({call_req, vec_addr}, {1'b1, 8'h3B}, "R8 disabled rx-err skipped");
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        #20 rst_n = 1; tick();
        t_timer_latency();
        t_ranking();
        t_nesting();
        t_boundary();
        t_not_latched();
        t_edge_and_mask();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule